// File: doc/BRIEF.md
# Transport PCR Restamper

This block sits in the path of a transport stream remultiplexer and rewrites the program clock reference carried by each PCR-bearing packet. The aim is that a downstream decoder sees every clock reference as if the packet had crossed a path with a fixed delay. A free-running counter, advancing once per clock (one 27 MHz tick), timestamps each PCR-bearing packet when it enters the remultiplexer. The arrival stamps wait in order in a small queue. When the packet leaves, the block pairs it with its own arrival stamp and measures the real transit delay.

The block subtracts a configured constant delay from the measured delay and adds the result to the outgoing PCR. It does this sum in linear 27 MHz units, then splits the result back into a 33-bit base and an extension below 300. The constant delay is the same for every PCR of a program. It comes from the configured scheduling strategy: early packing uses the minimum delay, late packing uses the maximum, and middle packing uses the average of the two. A correction larger than the jitter budget (4 ms, 108000 ticks) raises an error flag that travels with the result.

Top module: `pcr_restamp`

## Requirements
- R1: The measured delay of a packet is the number of clock cycles between the cycle its `in_valid` is sampled and the cycle its `eg_valid` is sampled, taken modulo 2^TS_W.
- R2: The corrected PCR, in linear units (base*300 + extension), equals the egress PCR plus (measured delay minus constant delay).
- R3: With `strategy` = 2'b00 (early), the constant delay is `dly_min`.
- R4: With `strategy` = 2'b01 (late), the constant delay is `dly_max`.
- R5: With `strategy` = 2'b10 or 2'b11 (middle), the constant delay is floor((`dly_min` + `dly_max`)/2).
- R6: `out_ext` is always in 0..299, and the base wraps modulo 2^33 in both directions (a positive carry past 2^33-1 gives 0, a negative borrow below 0 gives 2^33-1).
- R7: `out_err` is 1 with a result exactly when the correction magnitude exceeds 108000 ticks; a magnitude of exactly 108000 gives 0.
- R8: Egress strobes pair with pending ingress stamps in arrival order. Up to 4 stamps can be pending. An ingress and an egress in the same cycle are both accepted, and the egress uses the oldest stamp pending before that cycle.
- R9: An ingress strobe that arrives while 4 stamps are pending and no egress is accepted in that cycle is ignored.
- R10: An egress strobe that arrives with no stamp pending produces no result.
- R11: A result appears on the outputs with `out_valid` = 1 in the cycle after its egress strobe. In every other cycle `out_valid` is 0 and `out_base`, `out_ext` and `out_err` keep their last values, which are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | PCR-bearing packet enters the remultiplexer |
| eg_valid | input | 1 | PCR-bearing packet leaves the remultiplexer |
| eg_base | input | 33 | Carried PCR base of the leaving packet |
| eg_ext | input | 9 | Carried PCR extension of the leaving packet (0..299) |
| strategy | input | 2 | Scheduling strategy: 00 early, 01 late, 10/11 middle |
| dly_min | input | TS_W | Minimum path delay in ticks |
| dly_max | input | TS_W | Maximum path delay in ticks |
| out_valid | output | 1 | Corrected PCR present |
| out_base | output | 33 | Corrected PCR base |
| out_ext | output | 9 | Corrected PCR extension |
| out_err | output | 1 | Correction exceeded the jitter budget |

## Verification
An ingress stamp can be written into the queue in the same cycle that an egress strobe takes the oldest stamp out. The case that matters most is a simultaneous pair while the queue is empty or full. With an empty queue, the egress must give no result and the new stamp must stay pending. With a full queue, the new stamp must be accepted because the pop frees a slot. The bench provokes this with directed back-to-back pairs and with random streams where both strobes are frequent. It checks each later result against a reference queue of arrival cycle counts kept in the bench, so a wrongly paired or lost stamp shows up as a wrong delay in the corrected PCR.

// File: rtl/pcr_restamp_pkg.sv
package pcr_restamp_pkg;
   localparam int BASE_W  = 33;
   localparam int EXT_W   = 9;
   localparam int EXT_MOD = 300;
   localparam int LIN_W   = 43;

   typedef enum logic [1:0] {
      STRAT_EARLY = 2'b00,
      STRAT_LATE  = 2'b01,
      STRAT_MID   = 2'b10,
      STRAT_MID_A = 2'b11
   } strat_e;
endpackage

// File: rtl/pcr_ts_fifo.sv
module pcr_ts_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_req,
   input  logic         pop_req,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         pop_ok
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_depth_chk
      $error("pcr_ts_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          empty, full, push_ok;
   logic [W-1:0]  slot [DEPTH];

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign pop_ok  = pop_req && !empty;
   assign push_ok = push_req && (!full || pop_ok);
   assign rdata   = slot[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          slot[i] <= '0;
         else if (push_ok && wp == AW'(i))    slot[i] <= wdata;
      end
   end
endmodule

// File: rtl/pcr_const_sel.sv
module pcr_const_sel
   import pcr_restamp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [1:0]   strategy,
   input  logic [W-1:0] dly_min,
   input  logic [W-1:0] dly_max,
   output logic [W-1:0] cref
);
   logic [W:0] pair_sum;

   assign pair_sum = {1'b0, dly_min} + {1'b0, dly_max};

   always_comb begin
      unique case (strat_e'(strategy))
         STRAT_EARLY: cref = dly_min;
         STRAT_LATE:  cref = dly_max;
         default:     cref = pair_sum[W:1];
      endcase
   end
endmodule

// File: rtl/pcr_rebuild.sv
module pcr_rebuild
   import pcr_restamp_pkg::*;
#(
   parameter int CW = 33
) (
   input  logic [BASE_W-1:0]    base_i,
   input  logic [EXT_W-1:0]     ext_i,
   input  logic signed [CW-1:0] corr_i,
   output logic [BASE_W-1:0]    base_o,
   output logic [EXT_W-1:0]     ext_o
);
   localparam int SW = LIN_W + 2;
   localparam logic signed [SW-1:0] WRAP = SW'(EXT_MOD) << BASE_W;

   if (CW >= LIN_W) begin : g_cw_chk
      $error("pcr_rebuild: correction width must stay below the linear width");
   end

   logic signed [SW-1:0] lin, sum, fix;
   logic [SW-1:0]        ufix;

   always_comb begin
      lin = SW'(base_i) * SW'(EXT_MOD) + SW'(ext_i);
      sum = lin + SW'(corr_i);
      if (sum < 0)          fix = sum + WRAP;
      else if (sum >= WRAP) fix = sum - WRAP;
      else                  fix = sum;
      ufix = fix;
   end

   assign base_o = BASE_W'(ufix / SW'(EXT_MOD));
   assign ext_o  = EXT_W'(ufix % SW'(EXT_MOD));
endmodule

// File: rtl/pcr_restamp.sv
module pcr_restamp
   import pcr_restamp_pkg::*;
#(
   parameter int TS_W  = 32,
   parameter int DEPTH = 4,
   parameter int LIMIT = 108000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              eg_valid,
   input  logic [BASE_W-1:0] eg_base,
   input  logic [EXT_W-1:0]  eg_ext,
   input  logic [1:0]        strategy,
   input  logic [TS_W-1:0]   dly_min,
   input  logic [TS_W-1:0]   dly_max,
   output logic              out_valid,
   output logic [BASE_W-1:0] out_base,
   output logic [EXT_W-1:0]  out_ext,
   output logic              out_err
);
   localparam int CW = TS_W + 1;

   if (TS_W < 8 || TS_W > 40) begin : g_tsw_chk
      $error("pcr_restamp: TS_W out of range");
   end
   if (LIMIT < 1 || longint'(LIMIT) >= (longint'(1) << TS_W)) begin : g_lim_chk
      $error("pcr_restamp: LIMIT must fit the timestamp width");
   end

   logic [TS_W-1:0]        tick, head_ts, delay, cref;
   logic                   pop_ok, err_now;
   logic signed [CW-1:0]   corr, lim_s;
   logic [BASE_W-1:0]      new_base;
   logic [EXT_W-1:0]       new_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= '0;
      else        tick <= tick + 1'b1;
   end

   pcr_ts_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (in_valid),
      .pop_req  (eg_valid),
      .wdata    (tick),
      .rdata    (head_ts),
      .pop_ok   (pop_ok)
   );

   pcr_const_sel #(.W(TS_W)) u_const (
      .strategy (strategy),
      .dly_min  (dly_min),
      .dly_max  (dly_max),
      .cref     (cref)
   );

   assign delay   = tick - head_ts;
   assign corr    = $signed({1'b0, delay}) - $signed({1'b0, cref});
   assign lim_s   = CW'(LIMIT);
   assign err_now = (corr > lim_s) || (corr < -lim_s);

   pcr_rebuild #(.CW(CW)) u_rebuild (
      .base_i (eg_base),
      .ext_i  (eg_ext),
      .corr_i (corr),
      .base_o (new_base),
      .ext_o  (new_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_base  <= '0;
         out_ext   <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= pop_ok;
         if (pop_ok) begin
            out_base <= new_base;
            out_ext  <= new_ext;
            out_err  <= err_now;
         end
      end
   end
endmodule

// File: rtl/pcr_restamp_chk.sv
module pcr_restamp_chk #(
   parameter int DEPTH = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        eg_valid,
   input logic        out_valid,
   input logic [32:0] out_base,
   input logic [8:0]  out_ext
);
   logic [7:0] occ;
   logic       pop_m, push_m;

   assign pop_m  = eg_valid && (occ != 8'd0);
   assign push_m = in_valid && ((occ < 8'(DEPTH)) || pop_m);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= 8'd0;
      else        occ <= occ + 8'(push_m) - 8'(pop_m);
   end

   // R11
   out_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_m |=> out_valid);

   // R10
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_m |=> !out_valid);

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_m |=> ($stable(out_base) && $stable(out_ext)));

   // R6
   ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ext < 9'd300));
endmodule

bind pcr_restamp pcr_restamp_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .eg_valid  (eg_valid),
   .out_valid (out_valid),
   .out_base  (out_base),
   .out_ext   (out_ext)
);

// File: tb/pcr_restamp_test.sv
module pcr_restamp_test;
   localparam longint WRAP = longint'(300) << 33;
   localparam longint LIM  = 108000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, eg_valid = 1'b0;
   logic [32:0] eg_base = '0;
   logic [8:0]  eg_ext = '0;
   logic [1:0]  strategy = 2'b00;
   logic [31:0] dly_min = '0, dly_max = '0;
   logic        out_valid, out_err;
   logic [32:0] out_base;
   logic [8:0]  out_ext;

   int compared = 0, mismatched = 0;

   logic [1:0]  nx_strat = 2'b00;
   logic [31:0] nx_min = '0, nx_max = '0;

   logic [31:0] tbc;
   logic [31:0] mq [4];
   int          mcount = 0;

   bit          exp_v = 1'b0, exp_err = 1'b0;
   logic [32:0] exp_b = '0, hold_b = '0;
   logic [8:0]  exp_e = '0, hold_e = '0;
   bit          hold_err = 1'b0;
   string       exp_tag = "R11";

   always #10 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbc <= '0;
      else        tbc <= tbc + 1'b1;
   end

   pcr_restamp uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eg_valid(eg_valid),
      .eg_base(eg_base), .eg_ext(eg_ext), .strategy(strategy),
      .dly_min(dly_min), .dly_max(dly_max), .out_valid(out_valid),
      .out_base(out_base), .out_ext(out_ext), .out_err(out_err));

   function automatic longint const_of(logic [1:0] s, logic [31:0] mn, logic [31:0] mx);
      if (s == 2'b00)      return longint'(mn);
      else if (s == 2'b01) return longint'(mx);
      else                 return (longint'(mn) + longint'(mx)) / 2;
   endfunction

   function automatic longint fix_lin(longint lin, longint corr);
      longint s = lin + corr;
      if (s < 0)          s += WRAP;
      else if (s >= WRAP) s -= WRAP;
      return s;
   endfunction

   task automatic cmp(string tag, string what, longint got, longint exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic check_out();
      if (exp_v) begin
         cmp(exp_tag, "out_valid", out_valid, 1);
         cmp(exp_tag, "out_base", out_base, exp_b);
         cmp(exp_tag, "out_ext", out_ext, exp_e);
         cmp(exp_tag, "out_err", out_err, exp_err);
      end else begin
         // R10 / R11: no result, outputs held
         cmp("R10", "out_valid", out_valid, 0);
         cmp("R11", "held base", out_base, hold_b);
         cmp("R11", "held ext", out_ext, hold_e);
         cmp("R11", "held err", out_err, hold_err);
      end
      hold_b = out_base; hold_e = out_ext; hold_err = out_err;
   endtask

   task automatic step(bit iv, bit ev, logic [32:0] b, logic [8:0] e, string tag);
      bit pop, push;
      longint d, corr;
      @(negedge clk);
      check_out();
      in_valid = iv; eg_valid = ev; eg_base = b; eg_ext = e;
      strategy = nx_strat; dly_min = nx_min; dly_max = nx_max;
      pop  = ev && (mcount > 0);
      push = iv && ((mcount < 4) || pop);
      exp_v = pop;
      if (pop) begin
         d    = longint'(tbc - mq[0]);
         corr = d - const_of(nx_strat, nx_min, nx_max);
         d    = fix_lin(longint'(b) * 300 + longint'(e), corr);
         exp_b   = 33'(d / 300);
         exp_e   = 9'(d % 300);
         exp_err = (corr > LIM) || (corr < -LIM);
         exp_tag = tag;
         for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
         mcount--;
      end
      if (push) begin
         mq[mcount] = tbc;
         mcount++;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, "R11");
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R11: reset state
      @(negedge clk);
      cmp("R11", "reset out_valid", out_valid, 0);
      cmp("R11", "reset out_base", out_base, 0);
      cmp("R11", "reset out_ext", out_ext, 0);
      cmp("R11", "reset out_err", out_err, 0);

      // R1 / R4: delay of 10 cycles, late strategy with zero constant
      nx_strat = 2'b01; nx_min = 32'd0; nx_max = 32'd0;
      step(1'b1, 1'b0, '0, '0, "R1");
      idle(9);
      step(1'b0, 1'b1, 33'd1000, 9'd5, "R1");
      idle(2);

      // R7: boundary at exactly the budget (delay 1)
      nx_strat = 2'b01; nx_max = 32'd108001;
      step(1'b1, 1'b0, 33'd5000000, 9'd0, "R7");
      step(1'b0, 1'b1, 33'd5000000, 9'd0, "R7");
      nx_max = 32'd108002;
      step(1'b1, 1'b0, 33'd5000000, 9'd0, "R7");
      step(1'b0, 1'b1, 33'd5000000, 9'd0, "R7");
      idle(2);

      // R6: wrap upward then downward
      nx_strat = 2'b00; nx_min = 32'd0;
      step(1'b1, 1'b0, '0, '0, "R6");
      idle(2);
      step(1'b0, 1'b1, {33{1'b1}}, 9'd299, "R6");
      nx_strat = 2'b01; nx_max = 32'd50;
      step(1'b1, 1'b0, '0, '0, "R6");
      step(1'b0, 1'b1, 33'd0, 9'd0, "R6");
      idle(2);

      // R9: overfill the stamp queue, then drain
      nx_strat = 2'b10; nx_min = 32'd2; nx_max = 32'd9;
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, '0, '0, "R9");
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 33'(1000 * i), 9'(i), "R9");
      idle(2);

      // R8 / R10: simultaneous strobes on empty and on full queue
      nx_strat = 2'b11; nx_min = 32'd1; nx_max = 32'd4;
      step(1'b1, 1'b1, 33'd77, 9'd7, "R10");
      step(1'b1, 1'b1, 33'd88, 9'd8, "R8");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0, "R8");
      step(1'b1, 1'b1, 33'd99, 9'd9, "R8");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 33'(500 + i), 9'(i), "R8");
      idle(2);

      // R2 / R3 / R4 / R5: constrained random traffic
      for (int n = 0; n < 1500; n++) begin
         bit iv, ev;
         logic [32:0] b;
         string tg;
         nx_strat = 2'($urandom_range(0, 3));
         nx_min   = 32'($urandom_range(0, 200));
         nx_max   = nx_min + 32'($urandom_range(0, 300));
         if ($urandom_range(0, 7) == 0) nx_max = nx_max + 32'd150000;
         iv = ($urandom_range(0, 99) < 45);
         ev = ($urandom_range(0, 99) < 45);
         b  = {1'($urandom), 32'($urandom)};
         if (nx_strat == 2'b00)      tg = "R3";
         else if (nx_strat == 2'b01) tg = "R4";
         else if (n % 3 == 0)        tg = "R5";
         else                        tg = "R2";
         step(iv, ev, b, 9'($urandom_range(0, 299)), tg);
      end
      idle(3);
      finish_run();
   end
endmodule